// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over software that must prove it is alive at the right moment. Not too late and not too soon. A 7-bit counter runs down once per prescaled tick. The tick comes from the bus clock. It passes a fixed divider (4096 by default) and then a selectable divider of 1, 2, 4 or 8. Software arms the watchdog and sets a window value. It then refreshes the counter by writing a fresh count. If the count falls past the point where its top bit clears, the block raises a one-cycle reset pulse. It raises the same pulse when a refresh lands while the count is still above the window, or when the refresh value has its top bit clear. An early-warning flag rises one tick before a timeout, and a legal refresh drops it. A sticky cause flag records that the last reset came from the watchdog.

Configuration and refresh are plain write strobes with data. There is no stream data path and no back-pressure: every strobe is taken in the cycle it is presented. The counter value is visible on a read-back port. The block has two resets. The system reset `rst_n` returns all state except the cause flag. The power-on reset `por_n` clears that flag. In a chip, `wdg_reset` is fed into the system reset tree.

Top module: `wwdg_top`

## Requirements
- R1: After reset, `wdg_reset` and `early_warn` are 0, `count` reads 0x7F, and the watchdog is disarmed.
- R2: When armed, `count` drops by one every divider period P = FIX_DIV × 2^sel cycles, measured from the last counter load or arming. After a load of value V at clock edge E, the reset pulse is registered at edge E + (V − 0x3F)·P, which is the decrement from 0x40 to 0x3F.
- R3: The 2-bit `cfg_div_sel` encodes the extra divide as 0→÷1, 1→÷2, 2→÷4, 3→÷8.
- R4: An armed counter write while `count` > window is an early refresh. It raises `wdg_reset` at the very next edge and leaves `count` unchanged.
- R5: An armed counter write with `count` ≤ window and bit 6 of the data set is legal. It loads the counter, restarts the divider and raises no reset.
- R6: An armed counter write whose data has bit 6 clear raises `wdg_reset` at the next edge and is not loaded.
- R7: Arming via `cfg_enable`=1 is sticky. A configuration write with `cfg_enable`=0 does not disarm the watchdog; only `rst_n` or `por_n` does.
- R8: `early_warn` is set when a tick takes `count` from 0x41 to 0x40. It holds until a legal armed refresh, which clears it.
- R9: `reset_cause` is set together with every `wdg_reset` pulse. It survives `rst_n` and is cleared only by `por_n`.
- R10: While disarmed the counter does not run, and counter writes load any value without causing a reset.
- R11: `wdg_reset` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous; also clears cause flag |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_window | input | 7 | Window value; refreshes are legal only at or below it |
| cfg_div_sel | input | 2 | Extra divide select: 0 ÷1, 1 ÷2, 2 ÷4, 3 ÷8 |
| cfg_enable | input | 1 | Arm request (sticky once set) |
| cnt_we | input | 1 | Counter refresh strobe |
| cnt_wdata | input | 7 | New counter value |
| wdg_reset | output | 1 | One-cycle watchdog reset pulse |
| reset_cause | output | 1 | Sticky: last reset came from the watchdog |
| early_warn | output | 1 | Early-warning interrupt flag |
| count | output | 7 | Current counter value |

## Verification
The timeout path is run with each of the four divide selects and a short reload. The arrival cycle then tells apart each select value, and also an off-by-one in the divider or the compare. A refresh is tried above the window, below the window, and with the top bit clear. This separates the early-refresh check from the low-value check and from a plain legal load. A disarmed run with counter writes, a disarm attempt after arming, and a system reset between a watchdog event and a power-on reset separate the sticky arm bit from the sticky cause flag.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

  localparam int DIV_SEL_W = 2;

  typedef enum logic [DIV_SEL_W-1:0] {
    WWDG_DIV1 = 2'd0,
    WWDG_DIV2 = 2'd1,
    WWDG_DIV4 = 2'd2,
    WWDG_DIV8 = 2'd3
  } wwdg_div_e;

  typedef enum logic [1:0] {
    FIRE_NONE    = 2'd0,
    FIRE_TIMEOUT = 2'd1,
    FIRE_EARLY   = 2'd2,
    FIRE_LOWLOAD = 2'd3
  } wwdg_fire_e;

  localparam int SUB_W = 3;

  function automatic logic [SUB_W-1:0] div_mask(input wwdg_div_e sel);
    logic [SUB_W-1:0] m;
    case (sel)
      WWDG_DIV1: m = 3'b000;
      WWDG_DIV2: m = 3'b001;
      WWDG_DIV4: m = 3'b011;
      default:   m = 3'b111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/wwdg_cfg.sv
module wwdg_cfg
  import wwdg_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_window,
  input  logic [1:0]       cfg_div_sel,
  input  logic             cfg_enable,
  output logic [CNT_W-1:0] win_q,
  output wwdg_div_e        div_q,
  output logic             act_q,
  output logic             arm_pulse
);

  localparam logic [CNT_W-1:0] WIN_RST = {CNT_W{1'b1}};

  assign arm_pulse = cfg_we & cfg_enable & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= WIN_RST;
      div_q <= WWDG_DIV1;
      act_q <= 1'b0;
    end else if (cfg_we) begin
      win_q <= cfg_window;
      div_q <= wwdg_div_e'(cfg_div_sel);
      act_q <= act_q | cfg_enable;
    end
  end

endmodule

// File: rtl/wwdg_prescaler.sv
module wwdg_prescaler
  import wwdg_pkg::*;
#(
  parameter int FIX_DIV = 4096
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      restart,
  input  wwdg_div_e div_sel,
  output logic      tick
);

  localparam int BW = (FIX_DIV > 2) ? $clog2(FIX_DIV) : 1;
  localparam logic [BW-1:0] BASE_LAST = BW'(FIX_DIV - 1);

  logic [BW-1:0]    base_q;
  logic [SUB_W-1:0] sub_q;
  logic             base_wrap;
  logic [SUB_W-1:0] mask;

  assign base_wrap = (base_q == BASE_LAST);
  assign mask      = div_mask(div_sel);
  assign tick      = run & base_wrap & ((sub_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sub_q  <= '0;
    end else if (restart || !run) begin
      base_q <= '0;
      sub_q  <= '0;
    end else if (base_wrap) begin
      base_q <= '0;
      sub_q  <= sub_q + 1'b1;
    end else begin
      base_q <= base_q + 1'b1;
    end
  end

endmodule

// File: rtl/wwdg_core.sv
module wwdg_core
  import wwdg_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             active,
  input  logic [CNT_W-1:0] window,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             load_ok,
  output logic [CNT_W-1:0] count,
  output logic             wdg_reset,
  output logic             early_warn,
  output logic             reset_cause
);

  localparam int MSB = CNT_W - 1;
  localparam logic [CNT_W-1:0] THR     = CNT_W'(1) << MSB;
  localparam logic [CNT_W-1:0] WARN_AT = THR + CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_RST = {CNT_W{1'b1}};

  logic       bad_early, bad_low, dec, timeout;
  wwdg_fire_e fire;

  assign bad_early = active & cnt_we & (count > window);
  assign bad_low   = active & cnt_we & ~cnt_wdata[MSB];
  assign load_ok   = cnt_we & ~bad_early & ~bad_low;
  assign dec       = active & tick & ~cnt_we;
  assign timeout   = dec & (count == THR);

  always_comb begin
    fire = FIRE_NONE;
    if (!wdg_reset) begin
      if (bad_early)    fire = FIRE_EARLY;
      else if (bad_low) fire = FIRE_LOWLOAD;
      else if (timeout) fire = FIRE_TIMEOUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= CNT_RST;
      wdg_reset  <= 1'b0;
      early_warn <= 1'b0;
    end else begin
      wdg_reset <= (fire != FIRE_NONE);
      if (load_ok)  count <= cnt_wdata;
      else if (dec) count <= count - 1'b1;
      if (dec && count == WARN_AT)   early_warn <= 1'b1;
      else if (load_ok && active)    early_warn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 reset_cause <= 1'b0;
    else if (fire != FIRE_NONE) reset_cause <= 1'b1;
  end

endmodule

// File: rtl/wwdg_top.sv
module wwdg_top
  import wwdg_pkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int FIX_DIV = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_window,
  input  logic [1:0]       cfg_div_sel,
  input  logic             cfg_enable,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             wdg_reset,
  output logic             reset_cause,
  output logic             early_warn,
  output logic [CNT_W-1:0] count
);

  logic             sys_rst_n;
  logic [CNT_W-1:0] win_q;
  wwdg_div_e        div_q;
  logic             act_q, arm_pulse, tick, load_ok;

  assign sys_rst_n = rst_n & por_n;

  wwdg_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(sys_rst_n), .cfg_we(cfg_we), .cfg_window(cfg_window),
    .cfg_div_sel(cfg_div_sel), .cfg_enable(cfg_enable),
    .win_q(win_q), .div_q(div_q), .act_q(act_q), .arm_pulse(arm_pulse)
  );

  wwdg_prescaler #(.FIX_DIV(FIX_DIV)) u_pre (
    .clk(clk), .rst_n(sys_rst_n), .run(act_q),
    .restart(arm_pulse | load_ok), .div_sel(div_q), .tick(tick)
  );

  wwdg_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(sys_rst_n), .por_n(por_n), .active(act_q),
    .window(win_q), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .load_ok(load_ok), .count(count), .wdg_reset(wdg_reset),
    .early_warn(early_warn), .reset_cause(reset_cause)
  );

endmodule

// File: rtl/wwdg_chk.sv
module wwdg_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] window,
  input logic             active,
  input logic             wdg_reset,
  input logic             early_warn,
  input logic             reset_cause
);

  localparam int MSB = CNT_W - 1;
  localparam logic [CNT_W-1:0] THR = CNT_W'(1) << MSB;

  logic live_n;
  assign live_n = rst_n & por_n;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!live_n)
    wdg_reset |=> !wdg_reset); // R11

  AST_CAUSE_WITH_PULSE: assert property (@(posedge clk) disable iff (!live_n)
    wdg_reset |-> reset_cause); // R9

  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!por_n)
    reset_cause |=> reset_cause); // R9

  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!live_n)
    (cnt_we && active && count > window && !wdg_reset) |=> wdg_reset); // R4

  AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!live_n)
    (cnt_we && active && !cnt_wdata[MSB] && !wdg_reset) |=> wdg_reset); // R6

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!live_n)
    active |=> active); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!live_n)
    !active |=> !wdg_reset); // R10

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!live_n)
    !cnt_we |=> (count == $past(count) || count == CNT_W'($past(count) - 1'b1))); // R2

  AST_WARN_AT_THR: assert property (@(posedge clk) disable iff (!live_n)
    (!cnt_we && active && count == CNT_W'(THR + 1'b1)) |=> (count == THR -> early_warn)); // R8

endmodule

bind wwdg_top wwdg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .cnt_we(cnt_we),
  .cnt_wdata(cnt_wdata), .count(count), .window(win_q), .active(act_q),
  .wdg_reset(wdg_reset), .early_warn(early_warn), .reset_cause(reset_cause)
);

// File: tb/wwdg_top_tb_top.sv
module wwdg_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FIX       = 16;
  localparam int WD_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, por_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_enable = 1'b0, cnt_we = 1'b0;
  logic [6:0] cfg_window = '0, cnt_wdata = '0;
  logic [1:0] cfg_div_sel = '0;
  logic       wdg_reset, reset_cause, early_warn;
  logic [6:0] count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wwdg_top #(.CNT_W(7), .FIX_DIV(FIX)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cfg_we(cfg_we),
    .cfg_window(cfg_window), .cfg_div_sel(cfg_div_sel), .cfg_enable(cfg_enable),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .wdg_reset(wdg_reset),
    .reset_cause(reset_cause), .early_warn(early_warn), .count(count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    por_n = 1'b0; rst_n = 1'b0; cfg_we = 1'b0; cnt_we = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sys_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [6:0] win, input logic [1:0] sel, input logic en);
    cfg_we = 1'b1; cfg_window = win; cfg_div_sel = sel; cfg_enable = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [6:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  // Sample from n=1 (current negedge) up to maxn; report first reset, first warn, pulse count.
  task automatic measure(input int maxn, output int first_rst, output int first_ewi, output int pulses);
    first_rst = -1; first_ewi = -1; pulses = 0;
    for (int n = 1; n <= maxn; n++) begin
      if (n > 1) @(negedge clk);
      if (wdg_reset) begin
        pulses++;
        if (first_rst < 0) first_rst = n;
      end
      if (early_warn && first_ewi < 0) first_ewi = n;
    end
  endtask

  task automatic t_reset_state();
    hw_reset();
    chk("R1", "wdg_reset", wdg_reset, 0);
    chk("R1", "early_warn", early_warn, 0);
    chk("R1", "count", count, 7'h7F);
    chk("R9", "cause after por", reset_cause, 0);
  endtask

  task automatic t_idle();
    int fr, fe, p;
    hw_reset();
    measure(3000, fr, fe, p);
    chk("R1", "disarmed pulses", p, 0);
    chk("R10", "disarmed count frozen", count, 7'h7F);
    wr_cnt(7'h10);
    chk("R10", "disarmed low write no reset", wdg_reset, 0);
    chk("R10", "disarmed write loads", count, 7'h10);
  endtask

  task automatic t_timeout_flag();
    int fr, fe, p;
    hw_reset();
    wr_cfg(7'h7F, 2'd0, 1'b1);
    measure(1100, fr, fe, p);
    chk("R2", "timeout from arm", fr, 64*FIX + 1);
    chk("R8", "warn one tick early", fe, 63*FIX + 1);
    chk("R11", "single pulse", p, 1);
    chk("R9", "cause set", reset_cause, 1);
    sys_reset();
    chk("R9", "cause survives rst_n", reset_cause, 1);
    chk("R7", "rst_n disarms", count, 7'h7F);
    hw_reset();
    chk("R9", "cause cleared by por", reset_cause, 0);
  endtask

  task automatic t_div_sel();
    for (int s = 1; s < 4; s++) begin
      int fr, fe, p, per;
      per = FIX << s;
      hw_reset();
      wr_cfg(7'h7F, 2'(s), 1'b1);
      wr_cnt(7'h42);
      measure(3*per + 5, fr, fe, p);
      chk("R3", $sformatf("sel=%0d timeout", s), fr, 3*per + 1);
      chk("R8", $sformatf("sel=%0d warn", s), fe, 2*per + 1);
    end
  endtask

  task automatic t_early();
    hw_reset();
    wr_cfg(7'h50, 2'd0, 1'b1);
    wr_cnt(7'h60);
    chk("R4", "early refresh resets", wdg_reset, 1);
    chk("R4", "early refresh not loaded", count, 7'h7F);
    @(negedge clk);
    chk("R11", "pulse ends", wdg_reset, 0);
  endtask

  task automatic t_legal();
    int fr, fe, p, guard;
    hw_reset();
    wr_cfg(7'h50, 2'd0, 1'b1);
    guard = 0;
    while (count > 7'h50 && guard < 2000) begin
      @(negedge clk); guard++;
    end
    chk("R5", "reached window", count, 7'h50);
    wr_cnt(7'h70);
    chk("R5", "legal refresh no reset", wdg_reset, 0);
    chk("R5", "legal refresh loads", count, 7'h70);
    measure(800, fr, fe, p);
    chk("R5", "timeout after refresh", fr, 49*FIX + 1);
    hw_reset();
    wr_cfg(7'h7F, 2'd0, 1'b1);
    wr_cnt(7'h41);
    guard = 0;
    while (!early_warn && guard < 200) begin
      @(negedge clk); guard++;
    end
    chk("R8", "warn at 0x40", count, 7'h40);
    wr_cnt(7'h7F);
    chk("R8", "refresh clears warn", early_warn, 0);
    chk("R5", "refresh at 0x40 no reset", wdg_reset, 0);
  endtask

  task automatic t_low_and_sticky();
    hw_reset();
    wr_cfg(7'h7F, 2'd0, 1'b1);
    wr_cnt(7'h20);
    chk("R6", "bit6 clear resets", wdg_reset, 1);
    chk("R6", "bit6 clear not loaded", count, 7'h7F);
    hw_reset();
    wr_cfg(7'h7F, 2'd0, 1'b1);
    wr_cfg(7'h7F, 2'd0, 1'b0);
    wr_cnt(7'h20);
    chk("R7", "still armed after enable=0", wdg_reset, 1);
    sys_reset();
    wr_cnt(7'h20);
    chk("R7", "disarmed after rst_n", wdg_reset, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_idle();
    t_timeout_flag();
    t_div_sel();
    t_early();
    t_legal();
    t_low_and_sticky();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule